// File: doc/BRIEF.md
# Virtual Address Translation and Protection Checker

This block turns a 32-bit virtual address into a physical address together with a fault verdict. It sits between an address generator and a translation lookaside buffer: the lookup array itself lives outside and hands in its result, which is one of miss, single hit or multiple hit. On a hit it also hands in the matched entry's physical page number, page-size code, two protection bits and dirty bit. The block is purely combinational. It gives a physical address, a fault flag and a 12-bit exception code in the same cycle as its inputs.

Parts of the address space bypass translation altogether. The window 0x8000_0000..0xBFFF_FFFF is folded onto the low 512 MB. Addresses at or above 0xE000_0000 pass through unchanged. In user mode only the slice 0xE000_0000..0xE3FF_FFFF of these regions may be reached. With the translation unit switched off, the remaining addresses are folded the same way. With it switched on, the lookup result decides the outcome and the entry's rights are checked against the privilege level and the access direction.

The checks are applied in a fixed order: region first, then the enable bit, then the lookup status, and last the permissions.

Top module: `vaddr_xlate_check`

## Requirements
- R1: A privileged access in 0x8000_0000..0xBFFF_FFFF never faults and yields paddr = vaddr & 0x1FFF_FFFF, whatever mmu_en and the lookup inputs are.
- R2: A privileged access at or above 0xE000_0000 never faults and yields paddr = vaddr, whatever mmu_en and the lookup inputs are.
- R3: A user access (priv_mode=0) to 0x8000_0000..0xBFFF_FFFF or to 0xE400_0000..0xFFFF_FFFF is an address error. Its code is 0x100 when access_kind is write (2) and 0x0C0 for fetch (0), read (1) or code 3. A user access to 0xE000_0000..0xE3FF_FFFF passes with paddr = vaddr.
- R4: With mmu_en=0, an address below 0x8000_0000 or in 0xC000_0000..0xDFFF_FFFF never faults and yields paddr = vaddr & 0x1FFF_FFFF, whatever the lookup inputs are.
- R5: With mmu_en=1 on a translated address, a lookup_stat of 2 or 3 (multiple hit) faults with code 0x140.
- R6: With mmu_en=1 on a translated address, lookup_stat 0 (miss) faults with code 0x060 for a write and 0x040 otherwise.
- R7: On a hit (lookup_stat 1) in user mode with ent_prot[1]=0, the access faults with code 0x0C0 for a write and 0x0A0 otherwise. This check takes precedence over R8 and R9.
- R8: On a hit, a write that passes R7 with ent_prot[0]=0 faults with code 0x0C0.
- R9: On a hit, a write that passes R7 and R8 with ent_dirty=0 faults with code 0x080. Fetches and reads ignore ent_prot[0] and ent_dirty.
- R10: A hit that passes every check does not fault. paddr = ({ent_ppn, 10'b0} & ~M) | (vaddr & M), where M = page size − 1 and ent_size codes 0,1,2,3 select 1 KB, 4 KB, 64 KB and 1 MB pages.
- R11: Whenever fault=1, paddr is 0. Whenever fault=0, exc_code is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vaddr | input | 32 | Virtual address of the access |
| access_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 treated as read |
| priv_mode | input | 1 | 1 privileged, 0 user |
| mmu_en | input | 1 | Translation unit enable |
| lookup_stat | input | 2 | 0 miss, 1 hit, 2 or 3 multiple hit |
| ent_ppn | input | 22 | Physical page number of the matched entry |
| ent_size | input | 2 | Page-size code of the matched entry |
| ent_prot | input | 2 | Bit 1 user access allowed, bit 0 write allowed |
| ent_dirty | input | 1 | Dirty flag of the matched entry |
| paddr | output | 32 | Physical address, 0 on a fault |
| fault | output | 1 | Access faulted |
| exc_code | output | 12 | Exception code, 0 when no fault |

## Verification
The hardest situations to reach are those where several fault causes hold at once. One example is a user-mode write to an entry that lacks both the user-access bit and the write bit and is also clean. Another is a large page whose number carries set bits inside the offset field, so that the masking decides the result. Random stimulus only rarely lines these up, so directed vectors set every rights and dirty combination for each access kind on a hit. Further directed vectors use page numbers full of ones at all four size codes. The random part draws addresses region by region so that the boundaries at 0x8000_0000, 0xC000_0000, 0xE000_0000 and 0xE400_0000 are exercised, and it varies the lookup inputs in regions where they must have no effect.

// File: rtl/xlc_pkg.sv
package xlc_pkg;

    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 10;
    localparam int PPN_W      = VA_W - PAGE_SHIFT;
    localparam int EXC_W      = 12;
    localparam int OBITS_W    = $clog2(VA_W + 1);

    localparam logic [VA_W-1:0] FOLD_LO   = 32'h8000_0000;
    localparam logic [VA_W-1:0] FOLD_HI   = 32'hBFFF_FFFF;
    localparam logic [VA_W-1:0] PASS_LO   = 32'hE000_0000;
    localparam logic [VA_W-1:0] USERWIN_HI = 32'hE3FF_FFFF;
    localparam logic [VA_W-1:0] FOLD_MASK = 32'h1FFF_FFFF;

    localparam logic [EXC_W-1:0] EXC_NONE      = 12'h000;
    localparam logic [EXC_W-1:0] EXC_MISS_RD   = 12'h040;
    localparam logic [EXC_W-1:0] EXC_MISS_WR   = 12'h060;
    localparam logic [EXC_W-1:0] EXC_FIRST_WR  = 12'h080;
    localparam logic [EXC_W-1:0] EXC_PROT_RD   = 12'h0A0;
    localparam logic [EXC_W-1:0] EXC_PROT_WR   = 12'h0C0;
    localparam logic [EXC_W-1:0] EXC_ADDR_RD   = 12'h0C0;
    localparam logic [EXC_W-1:0] EXC_ADDR_WR   = 12'h100;
    localparam logic [EXC_W-1:0] EXC_MULTI     = 12'h140;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        LK_MISS   = 2'd0,
        LK_HIT    = 2'd1,
        LK_MULTI  = 2'd2,
        LK_MULTI3 = 2'd3
    } look_e;

    typedef enum logic [1:0] {
        RG_XLATE = 2'd0,
        RG_FOLD  = 2'd1,
        RG_PASS  = 2'd2
    } region_e;

    typedef struct packed {
        logic             fault;
        logic [EXC_W-1:0] code;
    } verdict_t;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [1:0]       size;
        logic [1:0]       prot;
        logic             dirty;
    } entry_t;

    function automatic logic [OBITS_W-1:0] offset_bits(input logic [1:0] sz);
        case (sz)
            2'd0:    return OBITS_W'(10);
            2'd1:    return OBITS_W'(12);
            2'd2:    return OBITS_W'(16);
            default: return OBITS_W'(20);
        endcase
    endfunction

    function automatic verdict_t mk_fault(input logic [EXC_W-1:0] c);
        verdict_t v;
        v.fault = 1'b1;
        v.code  = c;
        return v;
    endfunction

    function automatic verdict_t mk_ok();
        verdict_t v;
        v.fault = 1'b0;
        v.code  = EXC_NONE;
        return v;
    endfunction

endpackage

// File: rtl/xlc_region_decode.sv
module xlc_region_decode
    import xlc_pkg::*;
(
    input  logic [VA_W-1:0] va,
    input  logic            priv,
    input  logic            is_write,
    output region_e         kind,
    output verdict_t        verdict,
    output logic [VA_W-1:0] direct_pa
);
    logic in_fold;
    logic in_pass;
    logic in_userwin;

    always_comb begin
        in_fold    = (va >= FOLD_LO) && (va <= FOLD_HI);
        in_pass    = (va >= PASS_LO);
        in_userwin = in_pass && (va <= USERWIN_HI);

        if (in_fold)      kind = RG_FOLD;
        else if (in_pass) kind = RG_PASS;
        else              kind = RG_XLATE;

        verdict = mk_ok();
        if (!priv && (in_fold || (in_pass && !in_userwin)))
            verdict = mk_fault(is_write ? EXC_ADDR_WR : EXC_ADDR_RD);

        direct_pa = in_fold ? (va & FOLD_MASK) : va;
    end

    always_comb begin
        AST_USER_WINDOW_OPEN: assert (!(in_userwin && verdict.fault))
            else $error("user window must stay reachable"); // R3
    end

endmodule

// File: rtl/xlc_tlb_permit.sv
module xlc_tlb_permit
    import xlc_pkg::*;
(
    input  look_e    look,
    input  logic     priv,
    input  logic     is_write,
    input  entry_t   ent,
    output verdict_t verdict
);
    always_comb begin
        verdict = mk_ok();
        unique case (look)
            LK_MISS:
                verdict = mk_fault(is_write ? EXC_MISS_WR : EXC_MISS_RD);
            LK_HIT: begin
                if (!priv && !ent.prot[1])
                    verdict = mk_fault(is_write ? EXC_PROT_WR : EXC_PROT_RD);
                else if (is_write && !ent.prot[0])
                    verdict = mk_fault(EXC_PROT_WR);
                else if (is_write && !ent.dirty)
                    verdict = mk_fault(EXC_FIRST_WR);
            end
            default:
                verdict = mk_fault(EXC_MULTI);
        endcase
    end

    always_comb begin
        AST_FIRST_WRITE_ONLY_ON_WRITE: assert (!(verdict.code == EXC_FIRST_WR) || (is_write && look == LK_HIT && ent.prot[0]))
            else $error("initial write fault without a permitted write hit"); // R9
        AST_HIT_READ_PRIV_OK: assert (!(look == LK_HIT && priv && !is_write) || !verdict.fault)
            else $error("privileged read hit faulted"); // R9
    end

endmodule

// File: rtl/xlc_page_compose.sv
module xlc_page_compose
    import xlc_pkg::*;
(
    input  logic [VA_W-1:0]  va,
    input  logic [PPN_W-1:0] ppn,
    input  logic [1:0]       size,
    output logic [VA_W-1:0]  pa
);
    logic [OBITS_W-1:0] obits;
    logic [VA_W-1:0]    off_mask;
    logic [VA_W-1:0]    frame;

    always_comb begin
        obits    = offset_bits(size);
        off_mask = ({{(VA_W-1){1'b0}}, 1'b1} << obits) - {{(VA_W-1){1'b0}}, 1'b1};
        frame    = {ppn, {PAGE_SHIFT{1'b0}}};
        pa       = (frame & ~off_mask) | (va & off_mask);
    end

    always_comb begin
        AST_OFFSET_FROM_VA: assert (pa[PAGE_SHIFT-1:0] == va[PAGE_SHIFT-1:0])
            else $error("low offset bits lost"); // R10
        AST_TOP_FROM_PPN: assert (pa[VA_W-1:VA_W-4] == ppn[PPN_W-1:PPN_W-4])
            else $error("top frame bits lost"); // R10
    end

endmodule

// File: rtl/vaddr_xlate_check.sv
module vaddr_xlate_check
    import xlc_pkg::*;
(
    input  logic [31:0] vaddr,
    input  logic [1:0]  access_kind,
    input  logic        priv_mode,
    input  logic        mmu_en,
    input  logic [1:0]  lookup_stat,
    input  logic [21:0] ent_ppn,
    input  logic [1:0]  ent_size,
    input  logic [1:0]  ent_prot,
    input  logic        ent_dirty,
    output logic [31:0] paddr,
    output logic        fault,
    output logic [11:0] exc_code
);
    logic            is_write;
    region_e         rkind;
    verdict_t        rg_verdict;
    verdict_t        tl_verdict;
    logic [VA_W-1:0] direct_pa;
    logic [VA_W-1:0] page_pa;
    entry_t          ent;

    assign is_write = (acc_e'(access_kind) == ACC_WRITE);
    assign ent      = '{ppn: ent_ppn, size: ent_size, prot: ent_prot, dirty: ent_dirty};

    xlc_region_decode u_region (
        .va        (vaddr),
        .priv      (priv_mode),
        .is_write  (is_write),
        .kind      (rkind),
        .verdict   (rg_verdict),
        .direct_pa (direct_pa)
    );

    xlc_tlb_permit u_permit (
        .look     (look_e'(lookup_stat)),
        .priv     (priv_mode),
        .is_write (is_write),
        .ent      (ent),
        .verdict  (tl_verdict)
    );

    xlc_page_compose u_compose (
        .va   (vaddr),
        .ppn  (ent_ppn),
        .size (ent_size),
        .pa   (page_pa)
    );

    always_comb begin
        fault    = 1'b0;
        exc_code = EXC_NONE;
        paddr    = '0;
        if (rkind != RG_XLATE) begin
            if (rg_verdict.fault) begin
                fault    = 1'b1;
                exc_code = rg_verdict.code;
            end else begin
                paddr = direct_pa;
            end
        end else if (!mmu_en) begin
            paddr = vaddr & FOLD_MASK;
        end else if (tl_verdict.fault) begin
            fault    = 1'b1;
            exc_code = tl_verdict.code;
        end else begin
            paddr = page_pa;
        end
    end

    always_comb begin
        AST_FOLD_PRIV_CLEAN: assert (!(priv_mode && vaddr >= FOLD_LO && vaddr <= FOLD_HI) || (!fault && paddr[31:29] == 3'b000))
            else $error("privileged folded access misbehaved"); // R1
        AST_PASS_PRIV_CLEAN: assert (!(priv_mode && vaddr >= PASS_LO) || (!fault && paddr == vaddr))
            else $error("privileged pass-through access misbehaved"); // R2
        AST_MMU_OFF_CLEAN: assert (!(!mmu_en && vaddr < FOLD_LO) || !fault)
            else $error("disabled translation faulted"); // R4
        AST_MULTI_CODE: assert (!(mmu_en && vaddr < FOLD_LO && lookup_stat[1]) || exc_code == EXC_MULTI)
            else $error("multiple hit code wrong"); // R5
        AST_CODE_ZERO_WHEN_OK: assert (fault || exc_code == EXC_NONE)
            else $error("code set without fault"); // R11
    end

endmodule

// File: tb/vaddr_xlate_check_test.sv
module vaddr_xlate_check_test;

    logic        clk = 1'b0;
    logic [31:0] vaddr = '0;
    logic [1:0]  access_kind = '0;
    logic        priv_mode = 1'b0;
    logic        mmu_en = 1'b0;
    logic [1:0]  lookup_stat = '0;
    logic [21:0] ent_ppn = '0;
    logic [1:0]  ent_size = '0;
    logic [1:0]  ent_prot = '0;
    logic        ent_dirty = 1'b0;
    logic [31:0] paddr;
    logic        fault;
    logic [11:0] exc_code;

    int n_vec  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    vaddr_xlate_check uut (
        .vaddr       (vaddr),
        .access_kind (access_kind),
        .priv_mode   (priv_mode),
        .mmu_en      (mmu_en),
        .lookup_stat (lookup_stat),
        .ent_ppn     (ent_ppn),
        .ent_size    (ent_size),
        .ent_prot    (ent_prot),
        .ent_dirty   (ent_dirty),
        .paddr       (paddr),
        .fault       (fault),
        .exc_code    (exc_code)
    );

    task automatic model(output logic f, output logic [11:0] c,
                         output logic [31:0] pa, output string tag);
        logic wr;
        logic [31:0] sz;
        wr = (access_kind == 2'd2);
        f = 1'b0; c = 12'h000; pa = 32'h0;
        if (vaddr >= 32'h8000_0000 && vaddr < 32'hC000_0000) begin
            if (!priv_mode) begin f = 1'b1; c = wr ? 12'h100 : 12'h0C0; tag = "R3"; end
            else begin pa = {3'b000, vaddr[28:0]}; tag = "R1"; end
        end else if (vaddr >= 32'hE000_0000) begin
            if (!priv_mode && vaddr >= 32'hE400_0000) begin
                f = 1'b1; c = wr ? 12'h100 : 12'h0C0; tag = "R3";
            end else begin pa = vaddr; tag = priv_mode ? "R2" : "R3"; end
        end else if (!mmu_en) begin
            pa = {3'b000, vaddr[28:0]}; tag = "R4";
        end else if (lookup_stat >= 2'd2) begin
            f = 1'b1; c = 12'h140; tag = "R5";
        end else if (lookup_stat == 2'd0) begin
            f = 1'b1; c = wr ? 12'h060 : 12'h040; tag = "R6";
        end else if (!priv_mode && ent_prot[1] == 1'b0) begin
            f = 1'b1; c = wr ? 12'h0C0 : 12'h0A0; tag = "R7";
        end else if (wr && ent_prot[0] == 1'b0) begin
            f = 1'b1; c = 12'h0C0; tag = "R8";
        end else if (wr && !ent_dirty) begin
            f = 1'b1; c = 12'h080; tag = "R9";
        end else begin
            case (ent_size)
                2'd0: sz = 32'd1024;
                2'd1: sz = 32'd4096;
                2'd2: sz = 32'd65536;
                default: sz = 32'd1048576;
            endcase
            pa = (({ent_ppn, 10'b0}) & ~(sz - 1)) | (vaddr & (sz - 1));
            tag = "R10";
        end
    endtask

    task automatic apply(input logic [31:0] va, input logic [1:0] ak, input logic pm,
                         input logic me, input logic [1:0] ls, input logic [21:0] pp,
                         input logic [1:0] sz, input logic [1:0] pr, input logic dt);
        logic ef;
        logic [11:0] ec;
        logic [31:0] ep;
        string tag;
        @(posedge clk);
        vaddr = va; access_kind = ak; priv_mode = pm; mmu_en = me;
        lookup_stat = ls; ent_ppn = pp; ent_size = sz; ent_prot = pr; ent_dirty = dt;
        @(negedge clk);
        model(ef, ec, ep, tag);
        n_vec++;
        if (fault !== ef || exc_code !== ec || paddr !== ep) begin
            n_bad++;
            $display("FAIL %s va=%h: got fault=%b code=%h pa=%h, want fault=%b code=%h pa=%h",
                     tag, va, fault, exc_code, paddr, ef, ec, ep);
        end
        if (fault === 1'b1 && paddr !== 32'h0) begin
            n_bad++;
            $display("FAIL R11 va=%h: paddr=%h on fault, want 00000000", va, paddr);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1357_9BDF));
        // idle inputs: R4 path, all zero
        apply(32'h0, 2'd0, 1'b0, 1'b0, 2'd0, 22'h0, 2'd0, 2'd0, 1'b0);
        // R1 boundaries with hostile lookup inputs
        apply(32'h8000_0000, 2'd2, 1'b1, 1'b1, 2'd2, 22'h3FFFFF, 2'd3, 2'd0, 1'b0);
        apply(32'hBFFF_FFFF, 2'd1, 1'b1, 1'b1, 2'd0, 22'h0, 2'd0, 2'd0, 1'b0);
        // R2
        apply(32'hE000_0000, 2'd2, 1'b1, 1'b1, 2'd0, 22'h0, 2'd0, 2'd0, 1'b0);
        apply(32'hFFFF_FFFC, 2'd0, 1'b1, 1'b1, 2'd3, 22'h0, 2'd0, 2'd0, 1'b0);
        // R3 user address errors and the open window
        apply(32'h8000_0000, 2'd2, 1'b0, 1'b1, 2'd1, 22'h0, 2'd0, 2'd3, 1'b1);
        apply(32'hA000_1234, 2'd0, 1'b0, 1'b0, 2'd1, 22'h0, 2'd0, 2'd3, 1'b1);
        apply(32'hE400_0000, 2'd1, 1'b0, 1'b1, 2'd1, 22'h0, 2'd0, 2'd3, 1'b1);
        apply(32'hE400_0000, 2'd3, 1'b0, 1'b1, 2'd1, 22'h0, 2'd0, 2'd3, 1'b1);
        apply(32'hE3FF_FFFF, 2'd2, 1'b0, 1'b1, 2'd0, 22'h0, 2'd0, 2'd0, 1'b0);
        // R4 with translated high region and hit ignored
        apply(32'hDFFF_FFFF, 2'd2, 1'b0, 1'b0, 2'd2, 22'h0, 2'd0, 2'd0, 1'b0);
        apply(32'hC000_0000, 2'd1, 1'b1, 1'b0, 2'd0, 22'h0, 2'd0, 2'd0, 1'b0);
        // R5, R6
        apply(32'h0000_4000, 2'd1, 1'b1, 1'b1, 2'd2, 22'h0, 2'd0, 2'd3, 1'b1);
        apply(32'hC000_4000, 2'd2, 1'b0, 1'b1, 2'd3, 22'h0, 2'd0, 2'd3, 1'b1);
        apply(32'h7FFF_FFFF, 2'd2, 1'b1, 1'b1, 2'd0, 22'h0, 2'd0, 2'd3, 1'b1);
        apply(32'h7FFF_FFFF, 2'd0, 1'b1, 1'b1, 2'd0, 22'h0, 2'd0, 2'd3, 1'b1);
        // R7..R9: every rights/dirty combination, each kind, both modes
        for (int k = 0; k < 4; k++)
            for (int pm = 0; pm < 2; pm++)
                for (int pr = 0; pr < 4; pr++)
                    for (int dt = 0; dt < 2; dt++)
                        apply(32'h1234_5678, 2'(k), 1'(pm), 1'b1, 2'd1, 22'h2AAAAA, 2'd1, 2'(pr), 1'(dt));
        // R10: all-ones frame numbers at every size
        for (int s = 0; s < 4; s++) begin
            apply(32'h0ABC_DEF5, 2'd1, 1'b1, 1'b1, 2'd1, 22'h3FFFFF, 2'(s), 2'd0, 1'b0);
            apply(32'h0FFF_FFFF, 2'd2, 1'b0, 1'b1, 2'd1, 22'h000001, 2'(s), 2'd3, 1'b1);
        end
        // random part
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] va;
            int r;
            r  = $urandom % 6;
            va = $urandom;
            case (r)
                0: va[31] = 1'b0;
                1: va[31:30] = 2'b10;
                2: va[31:29] = 3'b110;
                3: va[31:26] = 6'b111000;
                4: begin va[31:29] = 3'b111; if (va[28:26] == 3'b000) va[26] = 1'b1; end
                default: ;
            endcase
            apply(va, 2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom % 3 == 0 ? $urandom : 1),
                  22'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule